// File: doc/BRIEF.md
# Debug Mailbox Flag and Data Registers

This block sits between a processor's debug and boot ROM routines and a JTAG test access port. It holds two 8-bit registers that the CPU reaches over a simple register bus. A status/control register carries a two-bit programming-source field, a system-program-enable bit and a transfer-done flag. A data register is the parallel holding stage for the TAP's debug shift register. The enable bit the CPU reads is the OR of its own writable copy and an enable bit kept on the TAP side. At reset, boot code reads this bit and, when it is set, runs in-system programming instead of jumping to user code. The programming-source field then picks the loader interface, or tells the loader to exit.

The TAP side gets the data register's current value at all times as its parallel load input. When the TAP signals the end of a transfer, the register captures the shift register's parallel output and the transfer-done flag is set. The CPU writes with a per-bit write mask. Any masked write that touches the enable bit or the transfer-done bit clears the programming-source field. The TAP state machine itself is not part of this block.

Top module: `dbg_link_regs`

## Requirements
- R1: After the synchronous reset `rst`, both registers read 0x00, `tap_load_data` is 0x00, and `prog_en` and all three source decode outputs are 0.
- R2: Bits 7:4 of the status register (address `FLAG_ADDR`) always read as 0, whatever the CPU writes there.
- R3: Status bit 1 reads as the OR of the CPU-writable enable bit and `tap_spe`. `prog_en` carries the same value.
- R4: The CPU-writable enable bit is cleared one cycle after `tap_tlr` or `tap_rod` is high. This clear wins over a CPU write in the same cycle.
- R5: A status write whose mask has bit 1 or bit 0 set clears the source field (bits 3:2) to 00. This happens whatever data is written and also when mask bits 3:2 are set in the same write.
- R6: A status write whose mask has bits 1:0 both clear updates the masked bits of the source field from `cpu_wdata[3:2]` and leaves the enable and done bits unchanged.
- R7: `tap_xfer_done` sets the transfer-done bit (status bit 0) on the next cycle, even if the CPU writes 0 to that bit in the same cycle.
- R8: With no transfer strobe, a status write with mask bit 0 set loads `cpu_wdata[0]` into the transfer-done bit. This lets the CPU clear it.
- R9: `tap_xfer_done` loads `tap_shift_out` into the data register on the next cycle. This takes priority over a CPU write to the data register in the same cycle.
- R10: A write to `BUF_ADDR` updates exactly the bits selected by `cpu_wmask`. `tap_load_data` always equals the data register's value.
- R11: While `prog_en` is 1, exactly one decode output is high: `src_jtag` for source 00, `src_i2c` for 01, `src_exit` for 1x. While `prog_en` is 0, all three are low.
- R12: Writes to any address other than `FLAG_ADDR` and `BUF_ADDR` change no state. Reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wmask | input | 8 | Per-bit write mask |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| tap_shift_out | input | 8 | Parallel output of the TAP debug shift register |
| tap_xfer_done | input | 1 | End-of-transfer strobe from the TAP |
| tap_spe | input | 1 | Program-enable bit held on the TAP side |
| tap_tlr | input | 1 | TAP is in Test-Logic-Reset |
| tap_rod | input | 1 | Strobe that clears the CPU enable bit |
| tap_load_data | output | 8 | Data register value for the shift register's parallel load |
| prog_en | output | 1 | Visible system-program enable |
| src_jtag | output | 1 | Loader source decode: JTAG |
| src_i2c | output | 1 | Loader source decode: I2C |
| src_exit | output | 1 | Loader decode: exit |

## Verification
The bench uses the default parameters: a 4-bit address, the status register at 0 and the data register at 1. Random addresses are biased toward the two mapped registers but still reach the fourteen unmapped ones, so the no-effect and read-zero rules are covered. With only 8 bits of state per register, random masks and data reach every source-field value, and reach collisions of the transfer strobe with CPU writes often. Directed cases pin down the priority corners: clear against write, strobe against write, and reset against strobe.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

    localparam int REG_W   = 8;
    localparam int TXC_BIT = 0;
    localparam int SPE_BIT = 1;
    localparam int SRC_LSB = 2;
    localparam int SRC_W   = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_JTAG  = 2'b00,
        SRC_I2C   = 2'b01,
        SRC_EXIT0 = 2'b10,
        SRC_EXIT1 = 2'b11
    } src_sel_e;

    typedef struct packed {
        src_sel_e src;
        logic     spe_cpu;
        logic     txc;
    } flag_t;

    typedef struct packed {
        logic jtag;
        logic i2c;
        logic exit_ldr;
    } src_dec_t;

    function automatic logic [REG_W-1:0] merge_bits(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [REG_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic [REG_W-1:0] flag_view(input flag_t f, input logic spe_vis);
        logic [REG_W-1:0] v;
        v = '0;
        v[TXC_BIT] = f.txc;
        v[SPE_BIT] = spe_vis;
        v[SRC_LSB +: SRC_W] = f.src;
        return v;
    endfunction

    function automatic src_dec_t decode_src(input src_sel_e s, input logic en);
        src_dec_t d;
        d = '0;
        if (en) begin
            unique case (s)
                SRC_JTAG:             d.jtag     = 1'b1;
                SRC_I2C:              d.i2c      = 1'b1;
                SRC_EXIT0, SRC_EXIT1: d.exit_ldr = 1'b1;
                default:              d          = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/dbg_flag_reg.sv
module dbg_flag_reg
    import dbg_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] wmask,
    input  logic             tap_done,
    input  logic             tap_tlr,
    input  logic             tap_rod,
    output flag_t            flag_q
);

    flag_t flag_d;
    logic  touch_ctl;

    assign touch_ctl = wr_en && (wmask[SPE_BIT] || wmask[TXC_BIT]);

    always_comb begin
        flag_d = flag_q;

        // enable bit: hardware clears beat the CPU write
        if (tap_tlr || tap_rod) begin
            flag_d.spe_cpu = 1'b0;
        end else if (wr_en && wmask[SPE_BIT]) begin
            flag_d.spe_cpu = wdata[SPE_BIT];
        end

        // transfer-done: hardware set beats the CPU write
        if (tap_done) begin
            flag_d.txc = 1'b1;
        end else if (wr_en && wmask[TXC_BIT]) begin
            flag_d.txc = wdata[TXC_BIT];
        end

        // source field: a write touching the control bits clears it
        if (touch_ctl) begin
            flag_d.src = SRC_JTAG;
        end else if (wr_en) begin
            flag_d.src = src_sel_e'((flag_q.src & ~wmask[SRC_LSB +: SRC_W]) |
                                    (wdata[SRC_LSB +: SRC_W] & wmask[SRC_LSB +: SRC_W]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/dbg_xfer_buf.sv
module dbg_xfer_buf
    import dbg_link_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wmask,
    input  logic         cap_en,
    input  logic [W-1:0] cap_data,
    output logic [W-1:0] buf_q
);

    logic [W-1:0] buf_d;

    always_comb begin
        buf_d = buf_q;
        if (cap_en) begin
            buf_d = cap_data;
        end else if (wr_en) begin
            for (int i = 0; i < W; i++) begin
                if (wmask[i]) buf_d[i] = wdata[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

endmodule

// File: rtl/dbg_rd_mux.sv
module dbg_rd_mux
    import dbg_link_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = '0,
    parameter logic [ADDR_W-1:0] BUF_ADDR  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  flag_t             flag_q,
    input  logic              tap_spe,
    input  logic [REG_W-1:0]  buf_q,
    output logic [REG_W-1:0]  rdata,
    output logic              spe_vis,
    output src_dec_t          dec
);

    assign spe_vis = flag_q.spe_cpu | tap_spe;
    assign dec     = decode_src(flag_q.src, spe_vis);

    always_comb begin
        if (addr == FLAG_ADDR) begin
            rdata = flag_view(flag_q, spe_vis);
        end else if (addr == BUF_ADDR) begin
            rdata = buf_q;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/dbg_link_regs.sv
module dbg_link_regs
    import dbg_link_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = '0,
    parameter logic [ADDR_W-1:0] BUF_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [7:0]        cpu_wmask,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic [7:0]        tap_shift_out,
    input  logic              tap_xfer_done,
    input  logic              tap_spe,
    input  logic              tap_tlr,
    input  logic              tap_rod,
    output logic [7:0]        tap_load_data,
    output logic              prog_en,
    output logic              src_jtag,
    output logic              src_i2c,
    output logic              src_exit
);

    flag_t            flag_q;
    logic [REG_W-1:0] buf_q;
    logic             flag_wr;
    logic             buf_wr;
    src_dec_t         dec;

    assign flag_wr = cpu_we && (cpu_addr == FLAG_ADDR);
    assign buf_wr  = cpu_we && (cpu_addr == BUF_ADDR);

    dbg_flag_reg u_flag (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (flag_wr),
        .wdata    (cpu_wdata),
        .wmask    (cpu_wmask),
        .tap_done (tap_xfer_done),
        .tap_tlr  (tap_tlr),
        .tap_rod  (tap_rod),
        .flag_q   (flag_q)
    );

    dbg_xfer_buf #(.W(REG_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (buf_wr),
        .wdata    (cpu_wdata),
        .wmask    (cpu_wmask),
        .cap_en   (tap_xfer_done),
        .cap_data (tap_shift_out),
        .buf_q    (buf_q)
    );

    dbg_rd_mux #(
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR),
        .BUF_ADDR  (BUF_ADDR)
    ) u_rd (
        .addr    (cpu_addr),
        .flag_q  (flag_q),
        .tap_spe (tap_spe),
        .buf_q   (buf_q),
        .rdata   (cpu_rdata),
        .spe_vis (prog_en),
        .dec     (dec)
    );

    assign tap_load_data = buf_q;
    assign src_jtag      = dec.jtag;
    assign src_i2c       = dec.i2c;
    assign src_exit      = dec.exit_ldr;

endmodule

// File: rtl/dbg_link_chk.sv
module dbg_link_chk #(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = '0,
    parameter logic [ADDR_W-1:0] BUF_ADDR  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_we,
    input logic [7:0]        cpu_wmask,
    input logic [7:0]        cpu_rdata,
    input logic [7:0]        tap_shift_out,
    input logic              tap_xfer_done,
    input logic              tap_spe,
    input logic              tap_tlr,
    input logic              tap_rod,
    input logic [7:0]        tap_load_data,
    input logic              prog_en,
    input logic              src_jtag,
    input logic              src_i2c,
    input logic              src_exit,
    input logic              txc_q,
    input logic [1:0]        src_q
);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == FLAG_ADDR) |-> (cpu_rdata[7:4] == 4'h0)); // R2

    AST_SPE_OR: assert property (@(posedge clk) disable iff (rst)
        tap_spe |-> prog_en); // R3

    AST_SPE_CLR: assert property (@(posedge clk) disable iff (rst)
        (tap_tlr || tap_rod) |=> (prog_en == tap_spe)); // R4

    AST_SRC_CLR: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == FLAG_ADDR && (cpu_wmask[1] || cpu_wmask[0])) |=> (src_q == 2'b00)); // R5

    AST_TXC_SET: assert property (@(posedge clk) disable iff (rst)
        tap_xfer_done |=> txc_q); // R7

    AST_BUF_CAP: assert property (@(posedge clk) disable iff (rst)
        tap_xfer_done |=> (tap_load_data == $past(tap_shift_out))); // R9

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> ($countones({src_jtag, src_i2c, src_exit}) == 1)); // R11

    AST_DEC_OFF: assert property (@(posedge clk) disable iff (rst)
        !prog_en |-> ({src_jtag, src_i2c, src_exit} == 3'b000)); // R11

    AST_RD_UNMAP: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr != FLAG_ADDR && cpu_addr != BUF_ADDR) |-> (cpu_rdata == 8'h00)); // R12

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tap_xfer_done && !(cpu_we && cpu_addr == BUF_ADDR)) |=> $stable(tap_load_data)); // R12

endmodule

bind dbg_link_regs dbg_link_chk #(
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .BUF_ADDR  (BUF_ADDR)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_addr      (cpu_addr),
    .cpu_we        (cpu_we),
    .cpu_wmask     (cpu_wmask),
    .cpu_rdata     (cpu_rdata),
    .tap_shift_out (tap_shift_out),
    .tap_xfer_done (tap_xfer_done),
    .tap_spe       (tap_spe),
    .tap_tlr       (tap_tlr),
    .tap_rod       (tap_rod),
    .tap_load_data (tap_load_data),
    .prog_en       (prog_en),
    .src_jtag      (src_jtag),
    .src_i2c       (src_i2c),
    .src_exit      (src_exit),
    .txc_q         (flag_q.txc),
    .src_q         (flag_q.src)
);

// File: tb/dbg_link_regs_tb.sv
module dbg_link_regs_tb;

    localparam int         ADDR_W = 4;
    localparam logic [3:0] FA = 4'd0;
    localparam logic [3:0] BA = 4'd1;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] cpu_addr;
    logic       cpu_we;
    logic [7:0] cpu_wmask, cpu_wdata, cpu_rdata;
    logic [7:0] tap_shift_out, tap_load_data;
    logic       tap_xfer_done, tap_spe, tap_tlr, tap_rod;
    logic       prog_en, src_jtag, src_i2c, src_exit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model state
    logic       m_spe, m_txc;
    logic [1:0] m_src;
    logic [7:0] m_buf;

    always #5 clk = ~clk;

    dbg_link_regs #(.ADDR_W(ADDR_W), .FLAG_ADDR(FA), .BUF_ADDR(BA)) u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wmask(cpu_wmask), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tap_shift_out(tap_shift_out), .tap_xfer_done(tap_xfer_done),
        .tap_spe(tap_spe), .tap_tlr(tap_tlr), .tap_rod(tap_rod),
        .tap_load_data(tap_load_data), .prog_en(prog_en),
        .src_jtag(src_jtag), .src_i2c(src_i2c), .src_exit(src_exit)
    );

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a == FA) return {4'h0, m_src, m_spe | tap_spe, m_txc};
        if (a == BA) return m_buf;
        return 8'h00;
    endfunction

    function automatic logic [2:0] exp_dec();
        logic en;
        en = m_spe | tap_spe;
        if (!en) return 3'b000;
        if (m_src == 2'b00) return 3'b100;
        if (m_src == 2'b01) return 3'b010;
        return 3'b001;
    endfunction

    task automatic model_step();
        logic fw, bw;
        fw = cpu_we && cpu_addr == FA;
        bw = cpu_we && cpu_addr == BA;
        if (rst) begin
            m_spe = 0; m_txc = 0; m_src = 0; m_buf = 0;
        end else begin
            if (tap_tlr || tap_rod) m_spe = 1'b0;
            else if (fw && cpu_wmask[1]) m_spe = cpu_wdata[1];
            if (tap_xfer_done) m_txc = 1'b1;
            else if (fw && cpu_wmask[0]) m_txc = cpu_wdata[0];
            if (fw && (cpu_wmask[1] || cpu_wmask[0])) m_src = 2'b00;
            else if (fw) m_src = (m_src & ~cpu_wmask[3:2]) | (cpu_wdata[3:2] & cpu_wmask[3:2]);
            if (tap_xfer_done) m_buf = tap_shift_out;
            else if (bw) m_buf = (m_buf & ~cpu_wmask) | (cpu_wdata & cpu_wmask);
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_we = 0; cpu_wmask = 0; cpu_wdata = 0;
        tap_xfer_done = 0; tap_tlr = 0; tap_rod = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] m, input logic [7:0] d);
        cpu_addr = a; cpu_we = 1; cpu_wmask = m; cpu_wdata = d;
        tick();
        idle();
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] lit);
        cpu_addr = a;
        #1;
        check(req, cpu_rdata, lit);
        check(req, cpu_rdata, exp_read(a));
    endtask

    task automatic check_outs(input string req);
        cpu_addr = FA;
        #1;
        check({req, "/R3"}, cpu_rdata, exp_read(FA));
        check({req, "/R11"}, {5'b0, src_jtag, src_i2c, src_exit}, {5'b0, exp_dec()});
        check({req, "/R10"}, tap_load_data, m_buf);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h1bad5eed));
        idle();
        cpu_addr = 0; tap_shift_out = 0; tap_spe = 0;
        rst = 1;
        tick(); tick();
        rst = 0;

        // R1: reset state
        rd_check("R1", FA, 8'h00);
        rd_check("R1", BA, 8'h00);
        check("R1", {4'b0, prog_en, src_jtag, src_i2c, src_exit}, 8'h00);

        // R2: reserved bits stay zero
        wr(FA, 8'hF0, 8'hF0);
        rd_check("R2", FA, 8'h00);

        // R6: source-only write; R11 decode with enable from tap side
        wr(FA, 8'h0C, 8'h04);
        rd_check("R6", FA, 8'h04);
        tap_spe = 1;
        rd_check("R3", FA, 8'h06);
        check("R11", {5'b0, src_jtag, src_i2c, src_exit}, 8'h02);
        wr(FA, 8'h0C, 8'h08);
        check("R11", {5'b0, src_jtag, src_i2c, src_exit}, 8'h01);
        tap_spe = 0;

        // R5: control-bit write clears source even when source written too
        wr(FA, 8'h0F, 8'h0E);
        rd_check("R5", FA, 8'h02);
        wr(FA, 8'h0C, 8'h0C);
        wr(FA, 8'h01, 8'h00);
        rd_check("R5", FA, 8'h02);

        // R4: tlr and rod clear the CPU enable, beating a same-cycle write
        cpu_addr = FA; cpu_we = 1; cpu_wmask = 8'h02; cpu_wdata = 8'h02; tap_tlr = 1;
        tick(); idle();
        rd_check("R4", FA, 8'h00);
        wr(FA, 8'h02, 8'h02);
        rd_check("R4", FA, 8'h02);
        tap_rod = 1; tick(); idle();
        rd_check("R4", FA, 8'h00);

        // R7: strobe sets done despite CPU clearing it; R9 capture beats CPU write
        tap_shift_out = 8'hA5;
        cpu_addr = FA; cpu_we = 1; cpu_wmask = 8'h01; cpu_wdata = 8'h00; tap_xfer_done = 1;
        tick(); idle();
        rd_check("R7", FA, 8'h01);
        check("R9", tap_load_data, 8'hA5);
        tap_shift_out = 8'h3C;
        cpu_addr = BA; cpu_we = 1; cpu_wmask = 8'hFF; cpu_wdata = 8'h00; tap_xfer_done = 1;
        tick(); idle();
        rd_check("R9", BA, 8'h3C);

        // R8: CPU clears done
        wr(FA, 8'h01, 8'h00);
        rd_check("R8", FA, 8'h00);

        // R10: masked buffer write
        wr(BA, 8'h0F, 8'hFF);
        rd_check("R10", BA, 8'h3F);
        check("R10", tap_load_data, 8'h3F);

        // R12: unmapped write and read
        wr(4'd7, 8'hFF, 8'hFF);
        rd_check("R12", 4'd7, 8'h00);
        rd_check("R12", BA, 8'h3F);
        rd_check("R12", FA, 8'h00);

        // random phase checked against the bench model
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            a = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 1));
            cpu_addr = a;
            cpu_we = $urandom_range(0, 1);
            cpu_wmask = 8'($urandom);
            cpu_wdata = 8'($urandom);
            tap_shift_out = 8'($urandom);
            tap_xfer_done = ($urandom_range(0, 5) == 0);
            tap_tlr = ($urandom_range(0, 20) == 0);
            tap_rod = ($urandom_range(0, 20) == 0);
            tap_spe = ($urandom_range(0, 3) == 0);
            tick();
            idle();
            check_outs("rand");
            cpu_addr = 4'($urandom_range(0, 15));
            #1;
            check("R12/R10", cpu_rdata, exp_read(cpu_addr));
        end

        // R1: reset in the same cycle as a strobe
        tap_xfer_done = 1; tap_shift_out = 8'hFF; rst = 1;
        tick(); idle(); rst = 0; tap_spe = 0;
        rd_check("R1", BA, 8'h00);
        rd_check("R1", FA, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule